// File: doc/BRIEF.md
# Pipelined Floating-Point Square Root

This unit computes the square root of one floating-point operand per clock. The exponent and fraction widths are parameters. Any format from a tiny 8-bit word up to IEEE double precision can be built. Operands arrive with a valid flag and leave, a fixed number of cycles later, with their own valid flag. That latency depends only on the fraction width. The pipeline never stalls, so a new operand can be presented on every clock.

The root of the significand is not formed digit by digit. The fraction's upper bits, together with the exponent's parity, select a segment of a small coefficient table, and the value is then expanded about the centre of that segment. The table holds the root, its first derivative and half its second derivative at the centre. The offset from the centre is applied through two short multiply-add steps. The exponent is halved exactly: an odd unbiased exponent first doubles the significand and is lowered by one. The result is truncated.

Special operands bypass the arithmetic:
- Subnormal inputs are flushed to zero.
- Zeros and positive infinity pass through unchanged.
- Any negative non-zero operand, including minus infinity, yields the canonical quiet NaN and raises an invalid flag.
- A NaN operand yields the same quiet NaN without the flag.

Top module: `flt_root_pipe`

## Requirements
- R1: The unit accepts an operand on every clock with no stall; every accepted operand produces exactly one result, in order.
- R2: A result appears on `out_valid` exactly LAT cycles after its operand was presented on `in_valid`. LAT is 9 for fraction widths up to 5, 12 up to 11, 13 up to 23 and 17 above (13 for the default 8/23 format).
- R3: For a normal positive operand with biased exponent E and bias B, the result exponent is B + floor((E - B)/2) and the sign bit is 0.
- R4: For a normal positive operand, the significand of the result (1.fraction) differs from the exact root of the operand's significand by less than 2 units in the last place. The operand's significand is doubled when E - B is odd.
- R5: An operand of +0 returns +0 and an operand of -0 returns -0, with `out_invalid` low.
- R6: An operand whose exponent field is 0 and whose fraction is non-zero is treated as a zero of the same sign: +sub returns +0 and -sub returns -0, with `out_invalid` low.
- R7: +infinity (exponent all ones, fraction 0, sign 0) returns +infinity with `out_invalid` low.
- R8: A negative operand that is neither zero, subnormal nor NaN returns the quiet NaN (sign 0, exponent all ones, fraction MSB 1, other fraction bits 0) with `out_invalid` high.
- R9: A NaN operand of either sign (exponent all ones, fraction non-zero) returns the same quiet NaN with `out_invalid` low.
- R10: `out_valid` is low while reset is asserted and stays low until the first result is due; while `out_valid` is high, `out_res` carries no unknown bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 1+EXP_W+MAN_W | Operand: sign, biased exponent, fraction |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 1+EXP_W+MAN_W | Square root in the same format |
| out_invalid | output | 1 | Result is the quiet NaN produced by a negative operand |

## Verification
The embedded assertions assume that every accepted operand is fully known (no X or Z on `in_op` while `in_valid` is high). They also assume `in_valid` is held low while reset is asserted and until the internal reset release has propagated. The range checks on the segment offset and on the raw root hold only for normal operands, and the class carried with each operand gates them. The bench drives `in_valid` low through reset and waits several cycles after release before the first operand. It uses only fully specified operand words, mixes back-to-back bursts with idle gaps, and takes random exponents only from the normal range. Each special class is reached with explicit vectors.

// File: rtl/flt_root_pkg.sv
package flt_root_pkg;

  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NORM  = 3'd0,
    CLS_ZERO  = 3'd1,
    CLS_PINF  = 3'd2,
    CLS_QNAN  = 3'd3,
    CLS_INVAL = 3'd4
  } root_cls_e;

  // Fixed depth per fraction width (R2)
  function automatic int pipe_latency(input int man_w);
    if (man_w <= 5)       return 9;
    else if (man_w <= 11) return 12;
    else if (man_w <= 23) return 13;
    else                  return 17;
  endfunction

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Bitwise integer square root, floor
  function automatic logic [127:0] isqrt128(input logic [127:0] x);
    logic [127:0] rem;
    logic [127:0] res;
    logic [127:0] bit_w;
    rem   = x;
    res   = '0;
    bit_w = 128'h1 << 126;
    for (int i = 0; i < 64; i++) begin
      if (rem >= res + bit_w) begin
        rem = rem - (res + bit_w);
        res = (res >> 1) + bit_w;
      end else begin
        res = res >> 1;
      end
      bit_w = bit_w >> 2;
    end
    return res;
  endfunction

  // Segment centre in fixed point with frac_w fraction bits.
  // seg = {odd, lo}: centre = (1 + (lo+0.5)/2^k) * (odd ? 2 : 1)
  function automatic logic [127:0] seg_center(input int seg, input int k, input int frac_w);
    logic [127:0] a;
    int           lo;
    lo = seg % (1 << k);
    a  = 128'(2 * ((1 << k) + lo) + 1);
    a  = a << (frac_w - k - 1);
    if (seg >= (1 << k)) a = a << 1;
    return a;
  endfunction

  function automatic logic [127:0] coef_root(input int seg, input int k, input int frac_w);
    return isqrt128(seg_center(seg, k, frac_w) << frac_w);
  endfunction

  function automatic logic [127:0] coef_slope(input int seg, input int k, input int frac_w);
    return (128'h1 << (2 * frac_w)) / (coef_root(seg, k, frac_w) << 1);
  endfunction

  function automatic logic [127:0] coef_curve(input int seg, input int k, input int frac_w);
    return (coef_slope(seg, k, frac_w) << frac_w) / (seg_center(seg, k, frac_w) << 2);
  endfunction

endpackage

// File: rtl/flt_root_unpack.sv
module flt_root_unpack #(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int IDX_W  = 7,
  parameter int FRAC_W = 27,
  parameter int VAL_W  = 30,
  parameter int SB_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] in_op,
  output logic                 out_valid,
  output logic [SB_W-1:0]      out_sb,
  output logic [VAL_W-1:0]     out_y,
  output logic [IDX_W:0]       out_idx
);
  import flt_root_pkg::*;

  localparam int GUARD_W = FRAC_W - MAN_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;

  logic                  op_sign;
  logic [EXP_W-1:0]      op_exp;
  logic [MAN_W-1:0]      op_frac;
  logic                  exp_zero;
  logic                  exp_ones;
  logic signed [EXP_W+1:0] e_unb;
  logic signed [EXP_W+1:0] e_half;
  logic signed [EXP_W+1:0] e_res;
  logic                  e_odd;
  root_cls_e             cls_nxt;
  logic [SB_W-1:0]       sb_nxt;
  logic [VAL_W-1:0]      y_nxt;
  logic [IDX_W:0]        idx_nxt;

  always_comb begin
    op_sign  = in_op[EXP_W+MAN_W];
    op_exp   = in_op[EXP_W+MAN_W-1:MAN_W];
    op_frac  = in_op[MAN_W-1:0];
    exp_zero = (op_exp == '0);
    exp_ones = (op_exp == '1);

    if (exp_ones && (op_frac != '0)) cls_nxt = CLS_QNAN;
    else if (exp_zero)               cls_nxt = CLS_ZERO;
    else if (op_sign)                cls_nxt = CLS_INVAL;
    else if (exp_ones)               cls_nxt = CLS_PINF;
    else                             cls_nxt = CLS_NORM;

    e_unb  = $signed({2'b00, op_exp}) - (EXP_W+2)'(BIAS);
    e_odd  = e_unb[0];
    e_half = e_unb >>> 1;
    e_res  = e_half + (EXP_W+2)'(BIAS);

    sb_nxt  = {cls_nxt, op_sign, e_res[EXP_W-1:0]};
    y_nxt   = {2'b00, 1'b1, op_frac, {GUARD_W{1'b0}}} << e_odd;
    idx_nxt = {e_odd, op_frac[MAN_W-1 -: IDX_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_sb  <= sb_nxt;
      out_y   <= y_nxt;
      out_idx <= idx_nxt;
    end
  end

  // R3
  norm_y_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sb[SB_W-1 -: CLS_W] == CLS_NORM)
      |-> (out_y >= (VAL_W'(1) << FRAC_W)) && (out_y < (VAL_W'(4) << FRAC_W)));

endmodule

// File: rtl/flt_root_seg.sv
module flt_root_seg #(
  parameter int IDX_W  = 7,
  parameter int FRAC_W = 27,
  parameter int VAL_W  = 30,
  parameter int SB_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [SB_W-1:0]         in_sb,
  input  logic [VAL_W-1:0]        in_y,
  input  logic [IDX_W:0]          in_idx,
  output logic                    out_valid,
  output logic [SB_W-1:0]         out_sb,
  output logic [VAL_W-1:0]        out_c0,
  output logic [VAL_W-1:0]        out_c1,
  output logic [VAL_W-1:0]        out_c2,
  output logic signed [VAL_W-1:0] out_d
);
  import flt_root_pkg::*;

  localparam int NSEG = 1 << (IDX_W + 1);
  localparam int HALF = 1 << (FRAC_W - IDX_W);

  logic [VAL_W-1:0] tab_c0 [NSEG];
  logic [VAL_W-1:0] tab_c1 [NSEG];
  logic [VAL_W-1:0] tab_c2 [NSEG];

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    localparam logic [127:0] C0_J = coef_root(j, IDX_W, FRAC_W);
    localparam logic [127:0] C1_J = coef_slope(j, IDX_W, FRAC_W);
    localparam logic [127:0] C2_J = coef_curve(j, IDX_W, FRAC_W);
    assign tab_c0[j] = C0_J[VAL_W-1:0];
    assign tab_c1[j] = C1_J[VAL_W-1:0];
    assign tab_c2[j] = C2_J[VAL_W-1:0];
  end

  logic [VAL_W-1:0]        ctr;
  logic signed [VAL_W-1:0] d_nxt;

  always_comb begin
    ctr   = VAL_W'({1'b1, in_idx[IDX_W-1:0], 1'b1}) << (FRAC_W - IDX_W - 1);
    ctr   = ctr << in_idx[IDX_W];
    d_nxt = $signed(in_y) - $signed(ctr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_sb <= in_sb;
      out_c0 <= tab_c0[in_idx];
      out_c1 <= tab_c1[in_idx];
      out_c2 <= tab_c2[in_idx];
      out_d  <= d_nxt;
    end
  end

  // R4
  seg_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sb[SB_W-1 -: CLS_W] == CLS_NORM)
      |-> (out_d >= -$signed(VAL_W'(HALF))) && (out_d <= $signed(VAL_W'(HALF))));

endmodule

// File: rtl/flt_root_poly.sv
module flt_root_poly #(
  parameter int FRAC_W = 27,
  parameter int VAL_W  = 30,
  parameter int SB_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [SB_W-1:0]         in_sb,
  input  logic [VAL_W-1:0]        in_c0,
  input  logic [VAL_W-1:0]        in_c1,
  input  logic [VAL_W-1:0]        in_c2,
  input  logic signed [VAL_W-1:0] in_d,
  output logic                    out_valid,
  output logic [SB_W-1:0]         out_sb,
  output logic signed [VAL_W-1:0] out_root
);
  import flt_root_pkg::*;

  localparam int PW = VAL_W + FRAC_W;

  // stage A: curve term
  logic                    va_q;
  logic [SB_W-1:0]         sba_q;
  logic signed [VAL_W-1:0] ta_q, da_q, c1a_q, c0a_q;
  // stage B: slope minus curve
  logic                    vb_q;
  logic [SB_W-1:0]         sbb_q;
  logic signed [VAL_W-1:0] ub_q, db_q, c0b_q;
  // stage C: times offset
  logic                    vc_q;
  logic [SB_W-1:0]         sbc_q;
  logic signed [VAL_W-1:0] wc_q, c0c_q;

  logic signed [PW-1:0]    pa_nxt, pc_nxt;
  logic signed [VAL_W-1:0] ta_nxt, ub_nxt, wc_nxt, r_nxt;

  always_comb begin
    pa_nxt = PW'($signed(in_c2)) * PW'(in_d);
    ta_nxt = VAL_W'(pa_nxt >>> FRAC_W);
    ub_nxt = c1a_q - ta_q;
    pc_nxt = PW'(ub_q) * PW'(db_q);
    wc_nxt = VAL_W'(pc_nxt >>> FRAC_W);
    r_nxt  = c0c_q + wc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q      <= 1'b0;
      vb_q      <= 1'b0;
      vc_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      va_q      <= in_valid;
      vb_q      <= va_q;
      vc_q      <= vb_q;
      out_valid <= vc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      sba_q <= in_sb;
      ta_q  <= ta_nxt;
      da_q  <= in_d;
      c1a_q <= $signed(in_c1);
      c0a_q <= $signed(in_c0);
    end
    if (va_q) begin
      sbb_q <= sba_q;
      ub_q  <= ub_nxt;
      db_q  <= da_q;
      c0b_q <= c0a_q;
    end
    if (vb_q) begin
      sbc_q <= sbb_q;
      wc_q  <= wc_nxt;
      c0c_q <= c0b_q;
    end
    if (vc_q) begin
      out_sb   <= sbc_q;
      out_root <= r_nxt;
    end
  end

  // R4
  slope_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_q && sbb_q[SB_W-1 -: CLS_W] == CLS_NORM)
      |-> (ub_q > $signed(VAL_W'(1) << (FRAC_W - 3))) && (ub_q < $signed(VAL_W'(1) << FRAC_W)));

endmodule

// File: rtl/flt_root_pipe.sv
module flt_root_pipe #(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int IDX_BITS = 7,
  parameter int GUARD_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] in_op,
  output logic                 out_valid,
  output logic [EXP_W+MAN_W:0] out_res,
  output logic                 out_invalid
);
  import flt_root_pkg::*;

  localparam int OP_W   = 1 + EXP_W + MAN_W;
  localparam int IDX_W  = min_int(IDX_BITS, MAN_W);
  localparam int FRAC_W = MAN_W + GUARD_W;
  localparam int VAL_W  = FRAC_W + 3;
  localparam int SB_W   = CLS_W + 1 + EXP_W;
  localparam int LAT    = pipe_latency(MAN_W);
  localparam int CORE   = 7;
  localparam int PAD    = LAT - CORE;
  localparam logic [OP_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [OP_W-1:0] PINF_WORD = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                    v1, v2, v6;
  logic [SB_W-1:0]         sb1, sb2, sb6;
  logic [VAL_W-1:0]        y1;
  logic [IDX_W:0]          idx1;
  logic [VAL_W-1:0]        c0_2, c1_2, c2_2;
  logic signed [VAL_W-1:0] d2, r6;

  flt_root_unpack #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .IDX_W(IDX_W),
    .FRAC_W(FRAC_W), .VAL_W(VAL_W), .SB_W(SB_W)
  ) u_unpack (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(in_valid), .in_op(in_op),
    .out_valid(v1), .out_sb(sb1), .out_y(y1), .out_idx(idx1)
  );

  flt_root_seg #(
    .IDX_W(IDX_W), .FRAC_W(FRAC_W), .VAL_W(VAL_W), .SB_W(SB_W)
  ) u_seg (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(v1), .in_sb(sb1), .in_y(y1), .in_idx(idx1),
    .out_valid(v2), .out_sb(sb2),
    .out_c0(c0_2), .out_c1(c1_2), .out_c2(c2_2), .out_d(d2)
  );

  flt_root_poly #(
    .FRAC_W(FRAC_W), .VAL_W(VAL_W), .SB_W(SB_W)
  ) u_poly (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(v2), .in_sb(sb2),
    .in_c0(c0_2), .in_c1(c1_2), .in_c2(c2_2), .in_d(d2),
    .out_valid(v6), .out_sb(sb6), .out_root(r6)
  );

  // pack stage
  root_cls_e        cls6;
  logic             sign6;
  logic [EXP_W-1:0] exp6;
  logic [MAN_W-1:0] frac_nxt;
  logic [OP_W-1:0]  res_nxt;
  logic             inv_nxt;

  always_comb begin
    cls6  = root_cls_e'(sb6[SB_W-1 -: CLS_W]);
    sign6 = sb6[EXP_W];
    exp6  = sb6[EXP_W-1:0];
    if (r6 >= $signed(VAL_W'(2) << FRAC_W))     frac_nxt = '1;
    else if (r6 < $signed(VAL_W'(1) << FRAC_W)) frac_nxt = '0;
    else                                        frac_nxt = MAN_W'(r6 >>> GUARD_W);
    inv_nxt = 1'b0;
    unique case (cls6)
      CLS_NORM:  res_nxt = {1'b0, exp6, frac_nxt};
      CLS_ZERO:  res_nxt = {sign6, {(OP_W-1){1'b0}}};
      CLS_PINF:  res_nxt = PINF_WORD;
      CLS_INVAL: begin
        res_nxt = QNAN_WORD;
        inv_nxt = 1'b1;
      end
      default:   res_nxt = QNAN_WORD;
    endcase
  end

  logic            pv_q   [PAD+1];
  logic [OP_W-1:0] pres_q [PAD+1];
  logic            pinv_q [PAD+1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pv_q[0] <= 1'b0;
    else            pv_q[0] <= v6;
  end

  always_ff @(posedge clk) begin
    if (v6) begin
      pres_q[0] <= res_nxt;
      pinv_q[0] <= inv_nxt;
    end
  end

  for (genvar i = 1; i <= PAD; i++) begin : g_pad
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) pv_q[i] <= 1'b0;
      else            pv_q[i] <= pv_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (pv_q[i-1]) begin
        pres_q[i] <= pres_q[i-1];
        pinv_q[i] <= pinv_q[i-1];
      end
    end
  end

  assign out_valid   = pv_q[PAD];
  assign out_res     = pres_q[PAD];
  assign out_invalid = pinv_q[PAD];

  // R4
  root_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (v6 && cls6 == CLS_NORM)
      |-> (r6 > $signed(VAL_W'(1) << (FRAC_W - 1))) && (r6 < $signed(VAL_W'(3) << FRAC_W)));

  // R8
  nan_word_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_invalid) |-> (out_res == QNAN_WORD));

  // R5
  neg_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_res[OP_W-1]) |-> (out_res[OP_W-2:0] == '0));

  // R10
  res_known_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> !$isunknown({out_res, out_invalid}));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> !out_valid);

endmodule

// File: tb/tb_flt_root_pipe.sv
module tb_flt_root_pipe;

  localparam int EW  = 8;
  localparam int MW  = 23;
  localparam int OW  = 1 + EW + MW;
  localparam int LAT = 13;
  localparam int BIAS = 127;
  localparam logic [OW-1:0] QNAN = 32'h7FC0_0000;
  localparam logic [OW-1:0] PINF = 32'h7F80_0000;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [OW-1:0] in_op;
  logic          out_valid;
  logic [OW-1:0] out_res;
  logic          out_invalid;

  flt_root_pipe dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_res(out_res), .out_invalid(out_invalid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int unsigned cyc;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk;
  int n_bad;
  bit done;

  logic [OW-1:0] exp_q  [$];
  int unsigned   stmp_q [$];
  logic [31:0]   lfsr;

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // driver: one operand per call, pushes it with its sampling edge stamp
  task automatic send(input logic [OW-1:0] op);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    exp_q.push_back(op);
    stmp_q.push_back(cyc + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op    = '0;
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // monitor: compares each result against the requirement for its operand
  always @(negedge clk) begin
    if (!done && rst_n && out_valid) begin
      logic [OW-1:0] op;
      int unsigned   st;
      logic [EW-1:0] e;
      logic [MW-1:0] f;
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "result with no operand pending", {32'h0, out_res}, 64'h0);
      end else begin
        op = exp_q.pop_front();
        st = stmp_q.pop_front();
        check((cyc - st) == LAT - 1, "R2", "latency", 64'(cyc - st + 1), 64'(LAT));
        e = op[OW-2:MW];
        f = op[MW-1:0];
        if (e == '1 && f != '0) begin
          check(out_res == QNAN && !out_invalid, "R9", "NaN operand",
                {31'h0, out_invalid, out_res}, {32'h0, QNAN});
        end else if (e == '0 && f == '0) begin
          check(out_res == op && !out_invalid, "R5", "zero operand",
                {31'h0, out_invalid, out_res}, {32'h0, op});
        end else if (e == '0) begin
          check(out_res == {op[OW-1], {(OW-1){1'b0}}} && !out_invalid, "R6", "subnormal flush",
                {31'h0, out_invalid, out_res}, {32'h0, op[OW-1], 31'h0});
        end else if (op[OW-1]) begin
          check(out_res == QNAN && out_invalid, "R8", "negative operand",
                {31'h0, out_invalid, out_res}, {31'h0, 1'b1, QNAN});
        end else if (e == '1) begin
          check(out_res == PINF && !out_invalid, "R7", "+inf operand",
                {31'h0, out_invalid, out_res}, {32'h0, PINF});
        end else begin
          int  eu, odd, eexp;
          real sig, tru, got, err;
          eu   = int'(e) - BIAS;
          odd  = eu & 1;
          eexp = (eu - odd) / 2 + BIAS;
          check(out_res[OW-1] == 1'b0 && int'(out_res[OW-2:MW]) == eexp && !out_invalid,
                "R3", "exponent", {32'h0, out_res}, 64'(eexp));
          sig = (1.0 + real'(f) / 8388608.0) * (odd != 0 ? 2.0 : 1.0);
          tru = $sqrt(sig);
          got = 1.0 + real'(out_res[MW-1:0]) / 8388608.0;
          err = got - tru;
          if (err < 0.0) err = -err;
          check(err < 2.0 / 8388608.0, "R4", "significand", {32'h0, out_res},
                64'($rtoi(tru * 8388608.0)));
        end
      end
    end
  end

  initial begin
    int unsigned t0;
    in_valid = 1'b0;
    in_op    = '0;
    rst_n    = 1'b0;
    lfsr     = 32'h1ACE_B00C;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid in reset", {63'h0, out_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after reset", {63'h0, out_valid}, 64'h0);

    // exact roots and exponent parity
    send(32'h3F80_0000);  // 1.0
    send(32'h4080_0000);  // 4.0
    send(32'h4000_0000);  // 2.0 odd exponent
    send(32'h4110_0000);  // 9.0
    send(32'h3E80_0000);  // 0.25
    send(32'h7F7F_FFFF);  // largest normal
    send(32'h0080_0000);  // smallest normal
    send(32'h3FFF_FFFF);  // just below 2.0
    idle(3);
    // special classes: R5 R6 R7 R8 R9
    send(32'h0000_0000);
    send(32'h8000_0000);
    send(32'h0000_0001);
    send(32'h807F_FFFF);
    send(PINF);
    send(32'hFF80_0000);  // -inf
    send(32'hBF80_0000);  // -1.0
    send(32'h7FC0_0001);
    send(32'hFFA0_0000);  // negative NaN
    idle(LAT + 2);
    check(exp_q.size() == 0, "R1", "results drained after gap", 64'(exp_q.size()), 64'h0);

    // R1: back-to-back burst of random positive normals
    t0 = cyc;
    for (int i = 0; i < 200; i++) begin
      logic [EW-1:0] ee;
      lfsr = next_rand(lfsr);
      ee   = lfsr[30:23];
      if (ee == '0) ee = 8'd1;
      if (ee == '1) ee = 8'hFE;
      send({1'b0, ee, lfsr[22:0]});
    end
    // mixed burst with gaps and signs
    for (int i = 0; i < 120; i++) begin
      lfsr = next_rand(lfsr);
      send(lfsr);
      if (lfsr[3:0] == 4'h0) idle(lfsr[6:4]);
    end
    idle(LAT + 3);
    check(exp_q.size() == 0, "R1", "all results returned", 64'(exp_q.size()), 64'h0);
    check((cyc - t0) > 0, "R1", "burst ran", 64'(cyc - t0), 64'h1);
    report();
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule